// File: doc/BRIEF.md
# Converter Output Pattern Formatter

This block is the last digital stage between the data paths of a dual 14-bit sampling converter and its output drivers. Each channel delivers a 14-bit offset-binary sample and an overflow flag, and the two channels share one sample-valid strobe. For every valid sample, the block builds a 15-bit output word per channel. Bit 14 is the overflow flag and bits 13..0 are the data. Three independent format options can be applied to the data: two's-complement conversion, randomization and alternate-bit inversion.

Instead of the formatted data, the block can emit one of four fixed test patterns on all 15 bits of both channels. A test pattern takes precedence over every format option and over the overflow flag. Two of the patterns change on every valid sample, so the block keeps a phase bit. That phase restarts whenever a different pattern code is selected.

A disable control drops the output-enable, which the pad ring uses to place the data, overflow and output-clock lines in high impedance. Everything is registered once: results appear on the clock edge after the sample is accepted.

Top module: `cvfmt_top`

## Requirements
- R1: While reset is high, and on the first edge after it, `out_valid_o` is 0, `out_word_o` is all zeros and `out_oe_o` is 0.
- R2: A sample accepted with `smp_valid_i` high at one rising edge appears on `out_word_o` with `out_valid_o` high at the next edge. When `smp_valid_i` is low, `out_valid_o` is 0 and `out_word_o` keeps its previous value, whatever the data inputs do.
- R3: With `pat_code_i` = 0 and `fmt_twos_i` = 1, data bit 13 (the MSB) is inverted.
- R4: With `pat_code_i` = 0 and `fmt_scramble_i` = 1, data bits 13..1 are each XORed with data bit 0, and bit 0 passes unchanged.
- R5: With `pat_code_i` = 0 and `fmt_flip_odd_i` = 1, data bits 1, 3, 5, 7, 9, 11 and 13 are inverted. The options apply in the order two's-complement, then randomizer, then odd-bit inversion.
- R6: With no pattern selected, word bit 14 carries the channel's overflow flag, and channel c occupies `out_word_o[15*c +: 15]`.
- R7: Code 1 drives all 15 bits of both channels to 1, and code 2 drives them all to 0, whatever the data, the overflow flag and the format options are.
- R8: Code 3 gives all ones on the first valid sample after the code is selected, then alternates between all zeros and all ones on each later valid sample. Both channels carry the same value.
- R9: Code 4 gives 15'h5555 (binary 101010101010101, bit 14 = 1) on the first valid sample after selection, then alternates between 15'h2AAA and 15'h5555 on each later valid sample.
- R10: The phase of codes 3 and 4 advances only on valid samples; cycles without a valid sample leave it unchanged.
- R11: Any change of `pat_code_i`, seen at a clock edge, restarts the phase. The next valid sample takes the first value of the sequence, including when the change falls on the same edge as that sample.
- R12: `out_oe_o` equals the inverse of `out_disable_i` sampled at the previous edge. The data path keeps formatting while the outputs are disabled.
- R13: Codes 5, 6 and 7 select no pattern: the output is the formatted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample-valid strobe, shared by both channels |
| smp_data_i | input | NUM_CH*DATA_W (28) | Offset-binary samples; channel c is at [14*c +: 14] |
| smp_ovf_i | input | NUM_CH (2) | Overflow flag per channel |
| fmt_twos_i | input | 1 | Enable two's-complement conversion |
| fmt_scramble_i | input | 1 | Enable randomizer |
| fmt_flip_odd_i | input | 1 | Enable alternate-bit inversion |
| pat_code_i | input | 3 | Test pattern: 0 none, 1 ones, 2 zeros, 3 alternating, 4 checkerboard, 5-7 none |
| out_disable_i | input | 1 | Request high-impedance outputs |
| out_valid_o | output | 1 | Output words hold a new sample |
| out_word_o | output | NUM_CH*(DATA_W+1) (30) | Output words; channel c is at [15*c +: 15], bit 14 = overflow |
| out_oe_o | output | 1 | Output enable for the pad ring |

## Verification
The bench targets the pattern phase. It sends runs of consecutive samples, puts idle gaps inside the alternating and checkerboard sequences, and switches pattern codes both between samples and on the same edge as a sample. A design whose phase ran on every clock, rather than on every sample, would lose step across the gaps. A design that did not restart the phase on a change of code would open the new pattern on its second value.

Patterns are also sent with every format option on and both overflow flags set. A design that placed the format logic after the pattern mux, or that let the overflow flag through, would corrupt the fixed words. The bench also drives data values whose bit 0 is set and clear under the randomizer, and codes 5 to 7. A wrong XOR source, or a decoder that treated those codes as patterns, would show up as data mismatches.

// File: rtl/cvfmt_pkg.sv
`timescale 1ns/1ps
package cvfmt_pkg;

    // Pattern select codes (R7, R8, R9, R13)
    typedef enum logic [2:0] {
        PAT_NONE  = 3'd0,
        PAT_ONES  = 3'd1,
        PAT_ZEROS = 3'd2,
        PAT_ALT   = 3'd3,
        PAT_CHECK = 3'd4
    } pat_sel_e;

    // Data format options, applied in field order
    typedef struct packed {
        logic twos;
        logic scramble;
        logic flip_odd;
    } fmt_opt_t;

    // Patterns whose value depends on the sample phase
    function automatic logic pat_toggles(input logic [2:0] code);
        return (code == PAT_ALT) || (code == PAT_CHECK);
    endfunction

endpackage

// File: rtl/cvfmt_phase.sv
`timescale 1ns/1ps
module cvfmt_phase
    import cvfmt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] pat_code_i,
    input  logic       smp_valid_i,
    output logic       phase_o
);

    logic [2:0] pat_q;
    logic       phase_q;
    logic       phase_d;

    // R10, R11: restart on any code change, advance only on valid samples
    always_comb begin
        phase_o = (pat_code_i != pat_q) ? 1'b0 : phase_q;
        phase_d = phase_o;
        if (!pat_toggles(pat_code_i)) begin
            phase_d = 1'b0;
        end else if (smp_valid_i) begin
            phase_d = ~phase_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pat_q   <= PAT_NONE;
            phase_q <= 1'b0;
        end else begin
            pat_q   <= pat_code_i;
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/cvfmt_pattern.sv
`timescale 1ns/1ps
module cvfmt_pattern
    import cvfmt_pkg::*;
#(
    parameter int unsigned WORD_W = 15
) (
    input  logic [2:0]        pat_code_i,
    input  logic              phase_i,
    output logic              active_o,
    output logic [WORD_W-1:0] word_o
);

    // First checkerboard phase: the top bit is 1, then bits alternate downward (R9)
    logic [WORD_W-1:0] check_a;

    for (genvar b = 0; b < WORD_W; b++) begin : g_check
        assign check_a[b] = (((WORD_W - 1 - b) % 2) == 0) ? 1'b1 : 1'b0;
    end

    always_comb begin
        active_o = 1'b1;
        word_o   = '0;
        case (pat_sel_e'(pat_code_i))
            PAT_ONES:  word_o = '1;
            PAT_ZEROS: word_o = '0;
            PAT_ALT:   word_o = phase_i ? '0 : '1;
            PAT_CHECK: word_o = phase_i ? ~check_a : check_a;
            default:   active_o = 1'b0;   // R13
        endcase
    end

endmodule

// File: rtl/cvfmt_xform.sv
`timescale 1ns/1ps
module cvfmt_xform
    import cvfmt_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  fmt_opt_t          opt_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] st_twos;
    logic [DATA_W-1:0] st_scr;

    // R3: offset binary to two's complement
    always_comb begin
        st_twos = data_i;
        if (opt_i.twos) begin
            st_twos[DATA_W-1] = ~data_i[DATA_W-1];
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // R4: randomizer keyed by the LSB
        if (b == 0) begin : g_lsb
            assign st_scr[b] = st_twos[b];
        end else begin : g_up
            assign st_scr[b] = st_twos[b] ^ (opt_i.scramble & st_twos[0]);
        end
        // R5: invert odd-numbered bits
        if ((b % 2) == 1) begin : g_odd
            assign data_o[b] = st_scr[b] ^ opt_i.flip_odd;
        end else begin : g_even
            assign data_o[b] = st_scr[b];
        end
    end

endmodule

// File: rtl/cvfmt_top.sv
`timescale 1ns/1ps
module cvfmt_top
    import cvfmt_pkg::*;
#(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned NUM_CH = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         smp_valid_i,
    input  logic [NUM_CH*DATA_W-1:0]     smp_data_i,
    input  logic [NUM_CH-1:0]            smp_ovf_i,
    input  logic                         fmt_twos_i,
    input  logic                         fmt_scramble_i,
    input  logic                         fmt_flip_odd_i,
    input  logic [2:0]                   pat_code_i,
    input  logic                         out_disable_i,
    output logic                         out_valid_o,
    output logic [NUM_CH*(DATA_W+1)-1:0] out_word_o,
    output logic                         out_oe_o
);

    localparam int unsigned WORD_W = DATA_W + 1;
    localparam int unsigned BUS_W  = NUM_CH * WORD_W;

    fmt_opt_t          opt;
    logic              phase;
    logic              pat_active;
    logic [WORD_W-1:0] pat_word;
    logic [BUS_W-1:0]  word_d;
    logic [BUS_W-1:0]  word_q;
    logic              valid_q;
    logic              oe_q;

    assign opt = '{twos: fmt_twos_i, scramble: fmt_scramble_i, flip_odd: fmt_flip_odd_i};

    cvfmt_phase u_phase (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pat_code_i  (pat_code_i),
        .smp_valid_i (smp_valid_i),
        .phase_o     (phase)
    );

    cvfmt_pattern #(.WORD_W(WORD_W)) u_pattern (
        .pat_code_i (pat_code_i),
        .phase_i    (phase),
        .active_o   (pat_active),
        .word_o     (pat_word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DATA_W-1:0] fmt_data;

        cvfmt_xform #(.DATA_W(DATA_W)) u_xform (
            .opt_i  (opt),
            .data_i (smp_data_i[c*DATA_W +: DATA_W]),
            .data_o (fmt_data)
        );

        // R7: a pattern overrides the data and the overflow flag; R6: layout
        assign word_d[c*WORD_W +: WORD_W] = pat_active ? pat_word
                                                       : {smp_ovf_i[c], fmt_data};
    end

    // R1, R2, R12: single output register stage
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q  <= '0;
            valid_q <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            valid_q <= smp_valid_i;
            oe_q    <= ~out_disable_i;
            if (smp_valid_i) begin
                word_q <= word_d;
            end
        end
    end

    assign out_word_o  = word_q;
    assign out_valid_o = valid_q;
    assign out_oe_o    = oe_q;

endmodule

// File: rtl/cvfmt_chk.sv
`timescale 1ns/1ps
module cvfmt_chk
    import cvfmt_pkg::*;
#(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned NUM_CH = 2
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic                         smp_valid_i,
    input logic                         ovf0_i,
    input logic [2:0]                   pat_code_i,
    input logic                         out_disable_i,
    input logic                         out_valid_o,
    input logic [NUM_CH*(DATA_W+1)-1:0] out_word_o,
    input logic                         out_oe_o
);

    localparam int unsigned WORD_W = DATA_W + 1;

    p_reset_r1: assert property (@(posedge clk_i)
        rst_i |=> (!out_valid_o && !out_oe_o && (out_word_o == '0)));

    p_valid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_valid_i |=> out_valid_o);

    p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_valid_i |=> (!out_valid_o && $stable(out_word_o)));

    p_ovf_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && pat_code_i == PAT_NONE) |=> (out_word_o[WORD_W-1] == $past(ovf0_i)));

    p_ones_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && pat_code_i == PAT_ONES) |=> (out_word_o == '1));

    p_alt_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && pat_code_i == PAT_ALT && $past(smp_valid_i) && $past(pat_code_i) == PAT_ALT)
        |=> (out_word_o[WORD_W-1:0] == ~$past(out_word_o[WORD_W-1:0])));

    p_check_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && pat_code_i == PAT_CHECK)
        |=> (&(out_word_o[WORD_W-1:1] ^ out_word_o[WORD_W-2:0])));

    p_oe_off_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        out_disable_i |=> !out_oe_o);

    p_oe_on_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        !out_disable_i |=> out_oe_o);

endmodule

bind cvfmt_top cvfmt_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .smp_valid_i   (smp_valid_i),
    .ovf0_i        (smp_ovf_i[0]),
    .pat_code_i    (pat_code_i),
    .out_disable_i (out_disable_i),
    .out_valid_o   (out_valid_o),
    .out_word_o    (out_word_o),
    .out_oe_o      (out_oe_o)
);

// File: tb/cvfmt_top_tb.sv
`timescale 1ns/1ps
module cvfmt_top_tb;

    localparam int DW = 14;
    localparam int NC = 2;
    localparam int WW = DW + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           smp_valid = 1'b0;
    logic [NC*DW-1:0] smp_data = '0;
    logic [NC-1:0]  smp_ovf = '0;
    logic           fmt_twos = 1'b0;
    logic           fmt_scramble = 1'b0;
    logic           fmt_flip_odd = 1'b0;
    logic [2:0]     pat_code = 3'd0;
    logic           out_disable = 1'b0;
    logic           out_valid;
    logic [NC*WW-1:0] out_word;
    logic           out_oe;

    always #2.5 clk = ~clk;

    cvfmt_top u_dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .smp_valid_i    (smp_valid),
        .smp_data_i     (smp_data),
        .smp_ovf_i      (smp_ovf),
        .fmt_twos_i     (fmt_twos),
        .fmt_scramble_i (fmt_scramble),
        .fmt_flip_odd_i (fmt_flip_odd),
        .pat_code_i     (pat_code),
        .out_disable_i  (out_disable),
        .out_valid_o    (out_valid),
        .out_word_o     (out_word),
        .out_oe_o       (out_oe)
    );

    typedef struct {
        logic [WW-1:0] w0;
        logic [WW-1:0] w1;
        string         tag;
    } exp_t;

    exp_t          sbq[$];
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;
    logic [2:0]    tb_pat = 3'd0;
    bit            tb_ph = 1'b0;
    logic [WW-1:0] last_w0 = '0;
    logic [WW-1:0] last_w1 = '0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic logic [WW-1:0] model(input logic [2:0] p, input bit ph,
                                            input logic tw, input logic sc, input logic fo,
                                            input logic [DW-1:0] d, input logic o);
        logic [DW-1:0] x;
        case (p)
            3'd1: return 15'h7FFF;
            3'd2: return 15'h0000;
            3'd3: return ph ? 15'h0000 : 15'h7FFF;
            3'd4: return ph ? 15'h2AAA : 15'h5555;
            default: begin
                x = d;
                if (tw) x = x ^ 14'h2000;
                if (sc && x[0]) x = x ^ 14'h3FFE;
                if (fo) x = x ^ 14'h2AAA;
                return {o, x};
            end
        endcase
    endfunction

    // Driver: one valid sample per call, expected result pushed to the scoreboard
    task automatic send(input logic [2:0] p, input logic tw, input logic sc, input logic fo,
                        input logic [DW-1:0] d0, input logic o0,
                        input logic [DW-1:0] d1, input logic o1, input string tag);
        exp_t e;
        @(negedge clk);
        if (p != tb_pat) tb_ph = 1'b0;
        tb_pat       = p;
        pat_code     = p;
        fmt_twos     = tw;
        fmt_scramble = sc;
        fmt_flip_odd = fo;
        smp_data     = {d1, d0};
        smp_ovf      = {o1, o0};
        smp_valid    = 1'b1;
        e.w0  = model(p, tb_ph, tw, sc, fo, d0, o0);
        e.w1  = model(p, tb_ph, tw, sc, fo, d1, o1);
        e.tag = tag;
        sbq.push_back(e);
        if (p == 3'd3 || p == 3'd4) tb_ph = ~tb_ph;
        else tb_ph = 1'b0;
    endtask

    // Idle cycles with moving data inputs (R2, R10)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = {14'(i * 977 + 5), 14'(i * 3131 + 1)};
            smp_ovf   = 2'(i);
        end
    endtask

    task automatic set_pat(input logic [2:0] p);
        @(negedge clk);
        smp_valid = 1'b0;
        if (p != tb_pat) tb_ph = 1'b0;
        tb_pat   = p;
        pat_code = p;
    endtask

    // Monitor: compare every output sample against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected output got %h expected none", out_word);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.tag, " ch0"}, 64'(out_word[WW-1:0]), 64'(e.w0));
                chk({e.tag, " ch1"}, 64'(out_word[2*WW-1:WW]), 64'(e.w1));
                last_w0 = e.w0;
                last_w1 = e.w1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset word", 64'(out_word), 64'd0);
        chk("R1 reset oe", 64'(out_oe), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 oe after reset", 64'(out_oe), 64'd1);

        // R6, R2: plain data with overflow
        send(3'd0, 0, 0, 0, 14'h1234, 1'b0, 14'h3FFF, 1'b1, "R6 plain");
        send(3'd0, 0, 0, 0, 14'h0001, 1'b1, 14'h2000, 1'b0, "R6 plain ovf");
        idle(4);
        chk("R2 hold ch0", 64'(out_word[WW-1:0]), 64'(last_w0));
        chk("R2 hold ch1", 64'(out_word[2*WW-1:WW]), 64'(last_w1));
        chk("R2 idle valid", 64'(out_valid), 64'd0);

        // R3, R4, R5: format options
        send(3'd0, 1, 0, 0, 14'h0000, 1'b0, 14'h2ABC, 1'b0, "R3 twos");
        send(3'd0, 0, 1, 0, 14'h1235, 1'b0, 14'h1234, 1'b1, "R4 scramble");
        send(3'd0, 0, 0, 1, 14'h0F0F, 1'b1, 14'h3FFF, 1'b0, "R5 flip odd");
        send(3'd0, 1, 1, 1, 14'h2001, 1'b0, 14'h1FFF, 1'b1, "R5 all options");

        // R13: unused codes behave as no pattern
        send(3'd5, 1, 0, 0, 14'h0100, 1'b1, 14'h0200, 1'b0, "R13 code5");
        send(3'd6, 0, 1, 0, 14'h0003, 1'b0, 14'h3FFE, 1'b1, "R13 code6");
        send(3'd7, 0, 0, 1, 14'h1555, 1'b1, 14'h2AAA, 1'b1, "R13 code7");

        // R7: constant patterns override options and overflow
        send(3'd1, 1, 1, 1, 14'h0000, 1'b0, 14'h1234, 1'b0, "R7 ones");
        send(3'd2, 1, 1, 1, 14'h3FFF, 1'b1, 14'h2345, 1'b1, "R7 zeros");

        // R8, R10: alternating with gaps
        send(3'd3, 1, 1, 1, 14'h0011, 1'b1, 14'h0022, 1'b1, "R8 alt first");
        send(3'd3, 1, 1, 1, 14'h0011, 1'b1, 14'h0022, 1'b1, "R8 alt second");
        idle(3);
        send(3'd3, 0, 0, 0, 14'h0033, 1'b0, 14'h0044, 1'b0, "R10 alt after gap");
        idle(1);
        send(3'd3, 0, 0, 0, 14'h0055, 1'b1, 14'h0066, 1'b0, "R10 alt after gap2");

        // R11: change on the sample edge restarts; R9 checkerboard
        send(3'd4, 1, 0, 1, 14'h0101, 1'b1, 14'h0202, 1'b1, "R11 R9 check first");
        send(3'd4, 1, 0, 1, 14'h0101, 1'b1, 14'h0202, 1'b1, "R9 check second");
        idle(2);
        send(3'd4, 0, 0, 0, 14'h0000, 1'b0, 14'h0000, 1'b0, "R10 check after gap");
        send(3'd3, 0, 0, 0, 14'h0000, 1'b0, 14'h0000, 1'b0, "R11 alt restart");
        send(3'd3, 0, 0, 0, 14'h0000, 1'b0, 14'h0000, 1'b0, "R11 alt step");

        // R11: away and back during idle restarts the sequence
        set_pat(3'd0);
        set_pat(3'd3);
        send(3'd3, 0, 0, 0, 14'h0777, 1'b1, 14'h0888, 1'b1, "R11 alt reselect");

        // R12: disable drops oe, data keeps flowing
        @(negedge clk);
        smp_valid   = 1'b0;
        out_disable = 1'b1;
        send(3'd0, 1, 0, 0, 14'h1111, 1'b1, 14'h2222, 1'b0, "R12 data while disabled");
        chk("R12 oe low", 64'(out_oe), 64'd0);
        idle(1);
        out_disable = 1'b0;
        @(negedge clk);
        chk("R12 oe high again", 64'(out_oe), 64'd1);

        idle(4);
        chk("R2 scoreboard drained", 64'(sbq.size()), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule